// File: doc/BRIEF.md
# Multiplexed Vacuum-Fluorescent Display Scanner

This block scans a multiplexed vacuum-fluorescent display. It works through the active digits one time slot at a time. For each digit it reads three bytes from an external byte-addressed display RAM, assembles up to twenty segment bits and drives them while the digit's grid is enabled. After the last digit, every frame ends with one extra slot. That slot enables no grid and raises a strobe so that key-matrix sampling logic can run.

A four-bit mode code sets how many digits are scanned. Eight output lines are shared between segment duty and grid duty, so each additional digit takes one segment away. Brightness comes from a three-bit dimming code. The code selects how many sixteenths of each slot the outputs stay lit, using a non-linear table. A display-enable bit blanks every output while the frame timing and the key-scan strobe keep running. Each slot lasts sixteen sixteenths, and each sixteenth is `TICKS_PER_SIXTEENTH` clock cycles long.

Top module: `vfd_scanner`

## Requirements
- R1: After reset the block scans 16 digits with 12 segments, has dimming code 7 and has the display disabled. All segment and grid outputs are 0 and `key_slot` first rises 16 slot lengths after reset is released.
- R2: Mode code bit 3 = 0 selects 8 digits. Codes 1000 to 1111 select 9 to 16 digits (9 + bits 2:0). The number of segments is always 28 minus the number of digits.
- R3: A frame is n+1 slots of 16 × TICKS_PER_SIXTEENTH cycles each. Slot n is the key-scan slot: `key_slot` is 1 and every segment and grid output is 0.
- R4: During digit slot k (0-based), grid_out bit k is the only grid bit that can be 1.
- R5: Digit k uses RAM bytes 3k, 3k+1 and 3k+2. Segment bits 0–7 come from byte 3k bits 0–7, bits 8–15 from byte 3k+1, and bits 16–19 from byte 3k+2 bits 0–3. Bits 4–7 of byte 3k+2 are ignored.
- R6: A shared pin seg_out[s] with s ≥ 28−n carries grid_out[27−s] and never segment data.
- R7: Dimming codes 0–7 give lit widths of 1, 2, 4, 10, 11, 12, 13 and 14 sixteenths. Outputs are lit only in sixteenths j < width, counted from the start of the slot.
- R8: With the display disabled, all segment and grid outputs are 0, while `key_slot` still occurs every n+1 slots.
- R9: A slot's segment data is read from RAM in the last three cycles of the preceding slot. A RAM change during a slot does not alter that slot's outputs.
- R10: A mode code loaded with `cfg_load` takes effect at the next frame boundary. Dimming and enable take effect on the cycle after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load pulse for the three settings below |
| cfg_mode | input | 4 | Digit/segment mode code |
| cfg_dim | input | 3 | Dimming code |
| cfg_disp_on | input | 1 | 1 = display enabled |
| ram_addr | output | 6 | Display RAM byte address |
| ram_rdata | input | 8 | Display RAM read data for ram_addr, same cycle |
| seg_out | output | 20 | Segment lines; the upper eight are shared with grids 16 down to 9 |
| grid_out | output | 16 | Grid enables, bit k = digit k |
| key_slot | output | 1 | High during the key-scan slot |

## Verification
All outputs are decoded from registered counters. A slot's values therefore appear in the same cycle the counters reach that slot and sixteenth. A new dimming or enable setting shows one cycle after the load, and a new mode shows only from the first slot after the next key slot. The bench aligns to the falling edge of `key_slot`, which marks slot 0, cycle 0. It then waits exactly k·16·T + j·T cycles and samples on the falling clock edge. RAM is modelled combinationally, so a write made during a slot must not show until the following frame.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int SEG_W   = 20;
  localparam int GRID_W  = 16;
  localparam int ADDR_W  = 6;

  // number of scanned digits for a mode code
  function automatic logic [4:0] digits_of_mode(input logic [3:0] code);
    return code[3] ? (5'd9 + {2'b00, code[2:0]}) : 5'd8;
  endfunction

  // segments left after the shared lines are taken by grids
  function automatic logic [4:0] segs_of_digits(input logic [4:0] n);
    return 5'd28 - n;
  endfunction

  // lit width in sixteenths per dimming code
  function automatic logic [4:0] lit_width(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd10;
      3'd4:    return 5'd11;
      3'd5:    return 5'd12;
      3'd6:    return 5'd13;
      default: return 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/vfd_timebase.sv
module vfd_timebase #(
  parameter int TICKS = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [4:0]                       n_digits,
  output logic [$clog2(16*TICKS)-1:0]      pos,
  output logic [3:0]                       sixteenth,
  output logic [4:0]                       slot,
  output logic                             slot_end,
  output logic                             frame_end
);
  localparam int SLOT_LEN = 16 * TICKS;
  localparam int POS_W    = $clog2(SLOT_LEN);
  localparam int TICK_W   = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(SLOT_LEN - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS - 1);

  logic [TICK_W-1:0] tick;
  logic              tick_last;

  assign tick_last = (tick == TICK_LAST);
  assign slot_end  = (pos == POS_LAST);
  assign frame_end = slot_end && (slot == n_digits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick      <= '0;
      pos       <= '0;
      sixteenth <= '0;
      slot      <= '0;
    end else begin
      tick <= tick_last ? '0 : tick + 1'b1;
      pos  <= slot_end ? '0 : pos + 1'b1;
      if (tick_last) sixteenth <= sixteenth + 4'd1;
      if (slot_end)  slot <= frame_end ? 5'd0 : slot + 5'd1;
    end
  end

  p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= n_digits);
  p_slot_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> (sixteenth == 4'd15) && tick_last);
endmodule

// File: rtl/vfd_fetch.sv
module vfd_fetch #(
  parameter int TICKS = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(16*TICKS)-1:0]      pos,
  input  logic [4:0]                       slot,
  input  logic [4:0]                       n_digits,
  input  logic                             slot_end,
  input  logic [7:0]                       ram_rdata,
  output logic [vfd_pkg::ADDR_W-1:0]       ram_addr,
  output logic [vfd_pkg::SEG_W-1:0]        seg_cur
);
  localparam int SLOT_LEN = 16 * TICKS;
  localparam int POS_W    = $clog2(SLOT_LEN);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(SLOT_LEN - 1);
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(SLOT_LEN - 3);

  logic       fetch_win;
  logic [1:0] byte_sel;
  logic [4:0] next_digit;
  logic [7:0] stage0, stage1;

  assign fetch_win  = (pos >= POS_FIRST);
  assign byte_sel   = (pos == POS_LAST) ? 2'd2 :
                      (pos == POS_LAST - 1'b1) ? 2'd1 : 2'd0;
  // the key slot and the slot before it both prefetch digit 0
  assign next_digit = (slot >= n_digits - 5'd1) ? 5'd0 : slot + 5'd1;
  assign ram_addr   = ({1'b0, next_digit} + {next_digit, 1'b0})
                      + {4'b0000, byte_sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage0  <= '0;
      stage1  <= '0;
      seg_cur <= '0;
    end else if (fetch_win) begin
      if (byte_sel == 2'd0) stage0 <= ram_rdata;
      if (byte_sel == 2'd1) stage1 <= ram_rdata;
      if (slot_end) seg_cur <= {ram_rdata[3:0], stage1, stage0};
    end
  end

  p_seg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(seg_cur));
  p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_addr < 6'd48);
endmodule

// File: rtl/vfd_drive.sv
module vfd_drive (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [4:0]                  slot,
  input  logic [4:0]                  n_digits,
  input  logic [3:0]                  sixteenth,
  input  logic                        disp_on,
  input  logic [2:0]                  dim_code,
  input  logic [vfd_pkg::SEG_W-1:0]   seg_cur,
  output logic [vfd_pkg::SEG_W-1:0]   seg_out,
  output logic [vfd_pkg::GRID_W-1:0]  grid_out,
  output logic                        key_slot
);
  import vfd_pkg::*;

  logic [4:0] width;
  logic [4:0] nseg;
  logic       lit;

  assign key_slot = (slot == n_digits);
  assign width    = lit_width(dim_code);
  assign nseg     = segs_of_digits(n_digits);
  assign lit      = disp_on && !key_slot && ({1'b0, sixteenth} < width);

  for (genvar g = 0; g < GRID_W; g++) begin : g_grid
    assign grid_out[g] = lit && (slot == 5'(g));
  end

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    if (s < 12) begin : g_dedicated
      assign seg_out[s] = lit && seg_cur[s];
    end else begin : g_shared
      assign seg_out[s] = (5'(s) >= nseg) ? grid_out[27-s] : (lit && seg_cur[s]);
    end
  end

  p_grid_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_out));
  p_key_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_slot |-> (grid_out == '0) && (seg_out == '0));
  p_off_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (grid_out == '0) && (seg_out == '0));
  p_dim_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sixteenth >= 4'd14) |-> (grid_out == '0));
  p_shared_grid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (n_digits == 5'd16) |-> seg_out[19:12] ==
      {grid_out[8], grid_out[9], grid_out[10], grid_out[11],
       grid_out[12], grid_out[13], grid_out[14], grid_out[15]});
endmodule

// File: rtl/vfd_scanner.sv
module vfd_scanner #(
  parameter int TICKS_PER_SIXTEENTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [3:0]  cfg_mode,
  input  logic [2:0]  cfg_dim,
  input  logic        cfg_disp_on,
  output logic [5:0]  ram_addr,
  input  logic [7:0]  ram_rdata,
  output logic [19:0] seg_out,
  output logic [15:0] grid_out,
  output logic        key_slot
);
  import vfd_pkg::*;
  localparam int POS_W = $clog2(16 * TICKS_PER_SIXTEENTH);

  logic [3:0]       mode_pend, mode_act;
  logic [2:0]       dim_r;
  logic             on_r;
  logic [4:0]       n_act;
  logic [POS_W-1:0] pos;
  logic [3:0]       sixteenth;
  logic [4:0]       slot;
  logic             slot_end, frame_end;
  logic [SEG_W-1:0] seg_cur;

  assign n_act = digits_of_mode(mode_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_pend <= 4'b1111;
      mode_act  <= 4'b1111;
      dim_r     <= 3'd7;
      on_r      <= 1'b0;
    end else begin
      if (cfg_load) begin
        mode_pend <= cfg_mode;
        dim_r     <= cfg_dim;
        on_r      <= cfg_disp_on;
      end
      if (frame_end) mode_act <= cfg_load ? cfg_mode : mode_pend;
    end
  end

  vfd_timebase #(.TICKS(TICKS_PER_SIXTEENTH)) u_timebase (
    .clk(clk), .rst_n(rst_n), .n_digits(n_act), .pos(pos),
    .sixteenth(sixteenth), .slot(slot), .slot_end(slot_end),
    .frame_end(frame_end));

  vfd_fetch #(.TICKS(TICKS_PER_SIXTEENTH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .pos(pos), .slot(slot), .n_digits(n_act),
    .slot_end(slot_end), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
    .seg_cur(seg_cur));

  vfd_drive u_drive (
    .clk(clk), .rst_n(rst_n), .slot(slot), .n_digits(n_act),
    .sixteenth(sixteenth), .disp_on(on_r), .dim_code(dim_r),
    .seg_cur(seg_cur), .seg_out(seg_out), .grid_out(grid_out),
    .key_slot(key_slot));

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(mode_act));
endmodule

// File: tb/test_vfd_scanner.sv
module test_vfd_scanner;
  localparam int T = 2;
  localparam int L = 16 * T;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [3:0]  cfg_mode = 4'd0;
  logic [2:0]  cfg_dim = 3'd0;
  logic        cfg_disp_on = 1'b0;
  logic [5:0]  ram_addr;
  logic [7:0]  ram_rdata;
  logic [19:0] seg_out;
  logic [15:0] grid_out;
  logic        key_slot;
  logic [7:0]  mem [48];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign ram_rdata = (ram_addr < 6'd48) ? mem[ram_addr] : 8'h00;

  vfd_scanner #(.TICKS_PER_SIXTEENTH(T)) i_vfd_scanner (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_dim(cfg_dim), .cfg_disp_on(cfg_disp_on), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .seg_out(seg_out), .grid_out(grid_out),
    .key_slot(key_slot));

  // {mode[3:0], dim[2:0], on, digit[4:0], sixteenth[3:0]}
  localparam logic [16:0] VEC [12] = '{
    {4'b0000, 3'd7, 1'b1, 5'd0,  4'd0},
    {4'b0101, 3'd7, 1'b1, 5'd7,  4'd13},
    {4'b0000, 3'd7, 1'b1, 5'd3,  4'd14},
    {4'b1000, 3'd0, 1'b1, 5'd8,  4'd0},
    {4'b1000, 3'd0, 1'b1, 5'd8,  4'd1},
    {4'b1011, 3'd2, 1'b1, 5'd11, 4'd3},
    {4'b1011, 3'd2, 1'b1, 5'd11, 4'd4},
    {4'b1111, 3'd3, 1'b1, 5'd15, 4'd9},
    {4'b1111, 3'd6, 1'b1, 5'd12, 4'd12},
    {4'b1100, 3'd1, 1'b0, 5'd5,  4'd0},
    {4'b1111, 3'd7, 1'b1, 5'd16, 4'd0},
    {4'b1010, 3'd5, 1'b1, 5'd11, 4'd0}
  };

  function automatic int ndig(input logic [3:0] m);
    if (m[3] == 1'b0) return 8;
    return 9 + int'(m[2:0]);
  endfunction

  function automatic int wid(input logic [2:0] d);
    int tbl [8] = '{1, 2, 4, 10, 11, 12, 13, 14};
    return tbl[d];
  endfunction

  function automatic logic [15:0] exp_grid(input logic [3:0] m, input logic [2:0] d,
                                           input logic on, input int k, input int j);
    logic [15:0] r = '0;
    if (on && k < ndig(m) && j < wid(d)) r[k] = 1'b1;
    return r;
  endfunction

  function automatic logic [19:0] exp_seg(input logic [3:0] m, input logic [2:0] d,
                                          input logic on, input int k, input int j);
    logic [19:0] raw, r;
    logic [15:0] g;
    int n = ndig(m);
    if (k >= n) return '0;
    g = exp_grid(m, d, on, k, j);
    raw = {mem[3*k+2][3:0], mem[3*k+1], mem[3*k]};
    for (int s = 0; s < 20; s++) begin
      if (s < 28 - n) r[s] = raw[s] & g[k];
      else            r[s] = g[27-s];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] m, input logic [2:0] d, input logic on);
    cfg_mode = m; cfg_dim = d; cfg_disp_on = on; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // leaves the bench at slot 0, cycle 0 of a frame
  task automatic sync_frame();
    while (key_slot !== 1'b1) @(negedge clk);
    while (key_slot !== 1'b0) @(negedge clk);
  endtask

  task automatic wait_cycles(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic [19:0] old_seg;
    for (int i = 0; i < 48; i++) mem[i] = 8'((i * 29 + 7) ^ (i << 5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, display dark, first key slot after 16 slots
    check("R1 seg after reset", 32'(seg_out), 32'd0);
    check("R1 grid after reset", 32'(grid_out), 32'd0);
    cnt = 0;
    while (key_slot !== 1'b1) begin @(negedge clk); cnt++; end
    check("R1 R3 first key slot cycle", 32'(cnt), 32'(16 * L));

    // vector walk: R2 R4 R5 R6 R7 R8 R3
    for (int v = 0; v < 12; v++) begin
      logic [3:0] m; logic [2:0] d; logic on; int k, j;
      m = VEC[v][16:13]; d = VEC[v][12:10]; on = VEC[v][9];
      k = int'(VEC[v][8:4]); j = int'(VEC[v][3:0]);
      load(m, d, on);
      sync_frame();
      wait_cycles(k * L + j * T);
      check($sformatf("R2 R5 R6 R7 seg v%0d", v), 32'(seg_out), 32'(exp_seg(m, d, on, k, j)));
      check($sformatf("R4 R8 grid v%0d", v), 32'(grid_out), 32'(exp_grid(m, d, on, k, j)));
      check($sformatf("R3 key_slot v%0d", v), 32'(key_slot), 32'(k == ndig(m)));
    end

    // R8: display off, key slot keeps its period of n+1 slots
    load(4'b1000, 3'd7, 1'b0);
    sync_frame();
    cnt = 0;
    while (key_slot !== 1'b1) begin @(negedge clk); cnt++; end
    check("R8 key slot with display off", 32'(cnt), 32'(9 * L));

    // R9: RAM write inside slot 1 does not reach slot 1
    load(4'b1111, 3'd7, 1'b1);
    sync_frame();
    wait_cycles(L + 2 * T);
    old_seg = exp_seg(4'b1111, 3'd7, 1'b1, 1, 2);
    mem[3] = ~mem[3];
    @(negedge clk);
    check("R9 mid-slot write held off", 32'(seg_out), 32'(old_seg));
    sync_frame();
    wait_cycles(L + 2 * T);
    check("R9 write visible next frame", 32'(seg_out), 32'(exp_seg(4'b1111, 3'd7, 1'b1, 1, 2)));

    // R10: mode waits for the frame boundary
    sync_frame();
    wait_cycles(3 * L);
    load(4'b0000, 3'd7, 1'b1);
    wait_cycles(5 * L - 1);
    check("R10 old mode still in frame key", 32'(key_slot), 32'd0);
    check("R10 old mode grid 9 lit", 32'(grid_out), 32'h0100);
    sync_frame();
    wait_cycles(8 * L);
    check("R10 new mode key slot at 8", 32'(key_slot), 32'd1);

    // R10 R7: dimming applies one cycle after load
    load(4'b1111, 3'd0, 1'b1);
    sync_frame();
    wait_cycles(2 * L + 5 * T);
    check("R7 dark past width 1", 32'(grid_out), 32'd0);
    load(4'b1111, 3'd7, 1'b1);
    check("R10 dim applied next cycle", 32'(grid_out), 32'h0004);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule